// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block keeps two extra bits per line beside a small direct-mapped data-cache tag array. The bits record which lines the running hardware transaction has read and which it has written. A core load or store that arrives while the transaction is active sets the matching bit on the line it touches. Incoming coherence snoops are checked against these bits, and a clash raises a one-cycle conflict pulse with a cause code for the transaction controller.

The controller ends a transaction with one of two strobes. A commit strobe clears every mark in one cycle. An abort strobe invalidates every write-marked line, reports the invalidated lines as a one-cycle mask, and clears all marks.

The tag array holds only a valid bit and a tag for each line. Its hit/miss result stands in for a real lookup. A miss on an unmarked line allocates at once. Data storage, refill and the full coherence protocol are out of scope.

Top module: `txset_tracker`

## Requirements
- R1: A load (`req_store`=0) with `req_in_tx`=1 sets the read mark of its line, whether it hits or allocates. A load with `req_in_tx`=0 updates the tag array but sets no mark.
- R2: A store (`req_store`=1) with `req_in_tx`=1 sets the write mark of its line, whether it hits or allocates.
- R3: An exclusive snoop (`snp_excl`=1) that hits a read-marked line raises `conflict` with `conflict_cause`=2'b01.
- R4: A snoop of either kind that hits a write-marked line raises `conflict` with `conflict_cause`=2'b10. This takes precedence over 2'b01.
- R5: A shared snoop (`snp_excl`=0) that hits a line carrying only a read mark, or any snoop that misses, causes no conflict.
- R6: When `tx_commit` is high and `tx_abort` is low, every read and write mark is clear after the next edge. Line valid bits and tags are unchanged.
- R7: When `tx_abort` is high (it wins over `tx_commit`), the following cycle shows `inv_mask` equal to the former write-mark vector. By then every line that was write-marked is invalid and all marks are clear. `inv_mask` is zero in every other cycle. Requests and snoops presented in a commit or abort cycle have no effect.
- R8: Lines are 64 bytes. Address bits [5:0] are ignored, bits [9:6] select one of the 16 lines, and the bits above bit 9 form the tag.
- R9: A request that misses on a valid line carrying any mark leaves that line unchanged and raises `conflict` with `conflict_cause`=2'b11. A snoop conflict in the same cycle takes precedence. A miss on an invalid or unmarked line allocates it.
- R10: `conflict` is a one-cycle pulse in the cycle after the event, with `conflict_cause` zero whenever `conflict` is low. After a pulse, further conflicts raise no pulse until an abort strobe.
- R11: After reset, all lines are invalid, all marks are clear, and `conflict` and `inv_mask` are zero.
- R12: `req_hit` is combinational and is high when `req_valid` is high and the request's line is valid with a matching tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_in_tx | input | 1 | Request issued inside a transaction |
| req_addr | input | ADDR_W | Request byte address |
| snp_valid | input | 1 | Snoop present |
| snp_excl | input | 1 | 1 = exclusive/invalidate, 0 = shared read |
| snp_addr | input | ADDR_W | Snoop byte address |
| tx_commit | input | 1 | Commit strobe |
| tx_abort | input | 1 | Abort strobe |
| req_hit | output | 1 | Request hits the tag array |
| conflict | output | 1 | Conflict-abort pulse |
| conflict_cause | output | 2 | 01 read-set, 10 write-set, 11 capacity |
| inv_mask | output | LINES | Lines invalidated by the last abort |
| line_valid | output | LINES | Per-line valid bits |
| rd_mark | output | LINES | Per-line transactional read marks |
| wr_mark | output | LINES | Per-line transactional write marks |

## Verification
The bench targets the following corner cases:
- A shared snoop to a read-only-marked line. A design that treats every snoop as a conflict would abort here.
- A second conflict while one is pending. A design without the latch would pulse again.
- Commit and abort raised together. If commit wins, written lines would survive that should have been invalidated.
- A miss on a marked line. A design that evicts the line would drop the tracking silently instead of raising the capacity cause.

Random traffic confined to three tags keeps hits, allocations and capacity misses frequent. The same traffic randomizes the low six address bits to show that the line offset is ignored.

// File: rtl/txset_tracker.sv
module txset_tracker #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 16,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_in_tx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              tx_commit,
  input  logic              tx_abort,
  output logic              req_hit,
  output logic              conflict,
  output logic [1:0]        conflict_cause,
  output logic [LINES-1:0]  inv_mask,
  output logic [LINES-1:0]  line_valid,
  output logic [LINES-1:0]  rd_mark,
  output logic [LINES-1:0]  wr_mark
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic             pending_q;

  wire [IDX_W-1:0] r_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] s_idx = snp_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1 -: TAG_W];

  wire quiet   = tx_commit | tx_abort;
  wire r_match = line_valid[r_idx] && (tag_q[r_idx] == r_tag);
  wire s_match = line_valid[s_idx] && (tag_q[s_idx] == s_tag);

  assign req_hit = req_valid && r_match;

  wire cap_cf = req_valid && !quiet && !r_match && line_valid[r_idx]
                && (rd_mark[r_idx] || wr_mark[r_idx]);
  wire req_ok = req_valid && !quiet && !cap_cf;
  wire wr_cf  = snp_valid && !quiet && s_match && wr_mark[s_idx];
  wire rd_cf  = snp_valid && !quiet && s_match && snp_excl && rd_mark[s_idx];

  wire [1:0] new_cause = wr_cf  ? 2'b10 :
                         rd_cf  ? 2'b01 :
                         cap_cf ? 2'b11 : 2'b00;
  wire fire = (new_cause != 2'b00) && !pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conflict       <= 1'b0;
      conflict_cause <= 2'b00;
      inv_mask       <= '0;
      line_valid     <= '0;
      rd_mark        <= '0;
      wr_mark        <= '0;
      pending_q      <= 1'b0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      conflict       <= fire;
      conflict_cause <= fire ? new_cause : 2'b00;
      inv_mask       <= tx_abort ? wr_mark : '0;
      if (tx_abort) begin
        line_valid <= line_valid & ~wr_mark;
        rd_mark    <= '0;
        wr_mark    <= '0;
        pending_q  <= 1'b0;
      end else if (tx_commit) begin
        rd_mark <= '0;
        wr_mark <= '0;
      end else begin
        if (fire) pending_q <= 1'b1;
        if (req_ok) begin
          if (!r_match) begin
            line_valid[r_idx] <= 1'b1;
            tag_q[r_idx]      <= r_tag;
          end
          if (req_in_tx && !req_store) rd_mark[r_idx] <= 1'b1;
          if (req_in_tx &&  req_store) wr_mark[r_idx] <= 1'b1;
        end
      end
    end
  end

  // R1
  rd_mark_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_in_tx && !req_store && !quiet && r_match) |=> rd_mark[$past(r_idx)]);

  // R2
  wr_mark_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_in_tx && req_store && !quiet && r_match) |=> wr_mark[$past(r_idx)]);

  // R6
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_commit && !tx_abort) |=> (rd_mark == '0 && wr_mark == '0 && $stable(line_valid)));

  // R7
  abort_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> (inv_mask == $past(wr_mark) && (line_valid & inv_mask) == '0
                  && rd_mark == '0 && wr_mark == '0));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> !conflict);

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |-> conflict_cause == 2'b00);
endmodule

// File: tb/txset_tracker_tb.sv
module txset_tracker_tb;
  localparam int ADDR_W = 32;
  localparam int LINES  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_in_tx = 0;
  logic [ADDR_W-1:0] req_addr = '0, snp_addr = '0;
  logic snp_valid = 0, snp_excl = 0, tx_commit = 0, tx_abort = 0;
  logic req_hit, conflict;
  logic [1:0] conflict_cause;
  logic [LINES-1:0] inv_mask, line_valid, rd_mark, wr_mark;

  always #5 clk = ~clk;

  txset_tracker #(.ADDR_W(ADDR_W), .LINES(LINES), .OFF_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_in_tx(req_in_tx), .req_addr(req_addr), .snp_valid(snp_valid),
    .snp_excl(snp_excl), .snp_addr(snp_addr), .tx_commit(tx_commit),
    .tx_abort(tx_abort), .req_hit(req_hit), .conflict(conflict),
    .conflict_cause(conflict_cause), .inv_mask(inv_mask),
    .line_valid(line_valid), .rd_mark(rd_mark), .wr_mark(wr_mark));

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [LINES-1:0] m_valid = '0, m_rd = '0, m_wr = '0, e_inv = '0;
  logic [21:0] m_tag [LINES];
  logic m_pend = 0, e_conf = 0, e_hit = 0;
  logic [1:0] e_cause = 0;

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int off);
    return ADDR_W'((tag << 10) | ((idx & 15) << 6) | (off & 63));
  endfunction

  task automatic chk(string lbl, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", lbl, what, act, exp);
    end
  endtask

  task automatic model_step();
    int ri = int'(req_addr[9:6]);
    int si = int'(snp_addr[9:6]);
    logic [21:0] rt = req_addr[31:10];
    logic [21:0] st = snp_addr[31:10];
    logic quiet = tx_commit | tx_abort;
    logic rh = m_valid[ri] && m_tag[ri] == rt;
    logic sh = m_valid[si] && m_tag[si] == st;
    logic cap = req_valid && !quiet && !rh && m_valid[ri] && (m_rd[ri] || m_wr[ri]);
    logic wcf = snp_valid && !quiet && sh && m_wr[si];
    logic rcf = snp_valid && !quiet && sh && snp_excl && m_rd[si];
    logic [1:0] c = wcf ? 2'b10 : rcf ? 2'b01 : cap ? 2'b11 : 2'b00;
    logic f = (c != 0) && !m_pend;
    e_hit   = req_valid && rh;
    e_conf  = f;
    e_cause = f ? c : 2'b00;
    e_inv   = tx_abort ? m_wr : '0;
    if (tx_abort) begin
      m_valid = m_valid & ~m_wr; m_rd = '0; m_wr = '0; m_pend = 0;
    end else if (tx_commit) begin
      m_rd = '0; m_wr = '0;
    end else begin
      if (f) m_pend = 1;
      if (req_valid && !cap) begin
        if (!rh) begin m_valid[ri] = 1; m_tag[ri] = rt; end
        if (req_in_tx && !req_store) m_rd[ri] = 1;
        if (req_in_tx && req_store)  m_wr[ri] = 1;
      end
    end
  endtask

  task automatic cyc(string lbl);
    #1;
    chk(lbl, "req_hit", 32'(req_hit), 32'(req_valid && m_valid[req_addr[9:6]]
        && m_tag[req_addr[9:6]] == req_addr[31:10]));
    model_step();
    @(posedge clk); #2;
    chk(lbl, "conflict", {30'd0, conflict, conflict_cause[0]} | 32'(conflict_cause) << 8,
        {30'd0, e_conf, e_cause[0]} | 32'(e_cause) << 8);
    chk(lbl, "inv_mask", 32'(inv_mask), 32'(e_inv));
    chk(lbl, "line_valid", 32'(line_valid), 32'(m_valid));
    chk(lbl, "rd_mark", 32'(rd_mark), 32'(m_rd));
    chk(lbl, "wr_mark", 32'(wr_mark), 32'(m_wr));
    req_valid = 0; snp_valid = 0; tx_commit = 0; tx_abort = 0;
  endtask

  task automatic req(logic st, logic tx, logic [ADDR_W-1:0] a);
    req_valid = 1; req_store = st; req_in_tx = tx; req_addr = a;
  endtask

  task automatic snp(logic ex, logic [ADDR_W-1:0] a);
    snp_valid = 1; snp_excl = ex; snp_addr = a;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) m_tag[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R11 reset state
    chk("R11", "line_valid", 32'(line_valid), 0);
    chk("R11", "marks", 32'({rd_mark, wr_mark}), 0);
    chk("R11", "conflict/inv", 32'({conflict, inv_mask}), 0);

    req(0, 1, mk(1, 1, 0));  cyc("R1");
    req(0, 0, mk(1, 2, 5));  cyc("R1");
    req(1, 1, mk(1, 3, 9));  cyc("R2");
    req(0, 1, mk(1, 1, 63)); cyc("R8");
    req(0, 0, mk(1, 2, 7));  cyc("R12");
    snp(0, mk(1, 1, 0));     cyc("R5");
    snp(1, mk(2, 1, 0));     cyc("R5");
    snp(1, mk(1, 1, 4));     cyc("R3");
    snp(1, mk(1, 3, 0));     cyc("R10");
    cyc("R10");
    tx_abort = 1; tx_commit = 1; snp(0, mk(1, 3, 0)); cyc("R7");
    cyc("R7");
    req(1, 1, mk(1, 4, 0));  cyc("R2");
    req(0, 1, mk(1, 1, 0));  snp(0, mk(1, 4, 0)); cyc("R4");
    tx_abort = 1; cyc("R7");
    req(0, 1, mk(1, 5, 0));  cyc("R9");
    req(0, 1, mk(2, 5, 0));  snp(0, mk(9, 9, 0)); cyc("R9");
    req(0, 1, mk(1, 5, 0));  cyc("R9");
    req(0, 0, mk(2, 1, 0));  cyc("R9");
    tx_abort = 1; cyc("R7");
    req(0, 1, mk(1, 6, 0));  cyc("R1");
    req(1, 1, mk(1, 7, 0));  cyc("R2");
    tx_commit = 1; req(1, 1, mk(1, 8, 0)); cyc("R6");
    req(1, 1, mk(1, 7, 0));  snp(1, mk(1, 6, 0)); snp(0, mk(1, 7, 0)); cyc("R4");
    tx_abort = 1; cyc("R7");

    for (int n = 0; n < 4000; n++) begin
      int p = int'($urandom_range(0, 99));
      if ($urandom_range(0, 3) != 0)
        req(1'($urandom), 1'($urandom_range(0, 4) != 0),
            mk(int'($urandom_range(0, 2)), int'($urandom_range(0, 15)), int'($urandom_range(0, 63))));
      if ($urandom_range(0, 2) == 0)
        snp(1'($urandom), mk(int'($urandom_range(0, 2)), int'($urandom_range(0, 15)), 0));
      if (p < 3) tx_commit = 1;
      else if (p < 7) tx_abort = 1;
      cyc("random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule